// File: doc/BRIEF.md
# I2C Transmit Status and NACK Lock Unit

This unit keeps the status of an I2C master's transfers. It sits next to the bus protocol engine and the transmit DMA channel. It holds the one-byte transmit and receive holding registers and the status flags. It also holds an interrupt mask, which software sets and clears with separate strobes, and from it drives one interrupt line. It gates the transmit DMA request. The engine fetches bytes through a request and availability handshake. It reports a STOP sent, a slave NACK and received bytes as single-cycle pulses.

A slave NACK locks the transmitter. Any byte still queued stays in the holding register and is not handed to the engine, and the DMA request is held low. The lock stays until software writes the unlock strobe. The transfer-complete flag is a live level and not a latched event. It is high at idle, and it reads low whenever the holding register holds a byte.

Top module: `i2c_txstat_lock`

## Requirements
- R1: After reset the status word `sr_rdata` is 32'h0000_0005: complete (bit 0) and TX ready (bit 2) are high, and every other bit is low. `imr_rdata` is zero and `irq` is low.
- R2: A control write with bit 0 set (START) clears the complete state. A write to the transmit holding register also clears it. An `eng_stop_done` pulse sets it only while `eng_busy` is low and the holding register is empty. A status read leaves bit 0 unchanged.
- R3: An `eng_nack` pulse sets, on the same clock edge, the NACK flag (bit 8), the lock flag (bit 23) and the complete state.
- R4: While the lock is set, `tx_avail` and `dma_tx_req` are low. An `eng_tx_req` neither takes the queued byte nor raises underrun. A queued byte holds status bit 0 low even though the complete state is set.
- R5: A control write with bit 26 set clears the lock, except when an `eng_nack` arrives in the same cycle, in which case the lock stays set. A control write with bit 24 set empties the transmit holding register.
- R6: `eng_rx_valid` loads `rhr_rdata` and sets RX ready (bit 1). `rhr_rd` or a control write with bit 25 set clears bit 1.
- R7: Overrun (bit 6) is set when a byte is received while bit 1 is high. Underrun (bit 7) is set when `eng_tx_req` finds the holding register empty and the lock clear.
- R8: An `sr_rd` pulse clears the overrun, underrun and NACK flags, unless the same flag is set in that same cycle.
- R9: `ier_wr` sets and `idr_wr` clears the mask bits selected by `mask_wdata`. If both strobes are given in one cycle, the disable wins. Only bits 0, 1, 2, 6, 7, 8 and 23 can be set. `imr_rdata` returns the mask.
- R10: `irq` is high exactly when some status bit and its mask bit are both high.
- R11: When `eng_tx_req` meets `tx_avail`, the engine takes the byte on `tx_byte` and the holding register empties. `dma_tx_req` is high when `dma_tx_en` is high, the holding register is empty and the lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control strobe write |
| ctl_wdata | input | 32 | Control strobe bits (0 START, 24 TX flush, 25 RX flush, 26 unlock) |
| thr_wr | input | 1 | Write to transmit holding register |
| thr_wdata | input | 8 | Byte to transmit |
| sr_rd | input | 1 | Status read, clears the read-clear flags |
| sr_rdata | output | 32 | Status word |
| rhr_rd | input | 1 | Receive holding register read |
| rhr_rdata | output | 8 | Received byte |
| ier_wr | input | 1 | Mask set strobe |
| idr_wr | input | 1 | Mask clear strobe |
| mask_wdata | input | 32 | Bits to set or clear in the mask |
| imr_rdata | output | 32 | Active interrupt mask |
| eng_tx_req | input | 1 | Engine asks for the next byte |
| tx_avail | output | 1 | A byte is queued and the transmitter is not locked |
| tx_byte | output | 8 | Queued byte |
| eng_busy | input | 1 | Engine shifter is busy |
| eng_stop_done | input | 1 | Pulse: STOP condition sent |
| eng_nack | input | 1 | Pulse: slave did not acknowledge |
| eng_rx_valid | input | 1 | Pulse: byte received |
| eng_rx_byte | input | 8 | Received byte |
| dma_tx_en | input | 1 | Transmit DMA channel armed |
| dma_tx_req | output | 1 | Transmit DMA request |
| irq | output | 1 | Interrupt |

## Verification
Some behaviours are checked on every clock cycle by the assertions:
- a NACK always leaves the lock, NACK and complete state set;
- an unlock never beats a simultaneous NACK;
- a locked holding register keeps its byte;
- a status read clears only those flags that are not set in the same cycle;
- each mask strobe moves exactly the bits it selects.

Other behaviours only the bench's scenarios can show:
- the live behaviour of status bit 0 through a whole transfer;
- the fixed bit positions in the status word;
- the priority when a read-clear and a new event meet;
- the return of the DMA request after an unlock and a flush;
- the interrupt line following each mask pattern in the vector table.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  localparam int REG_W = 32;

  // status word positions, decoded by software
  localparam int BIT_COMP  = 0;
  localparam int BIT_RXRDY = 1;
  localparam int BIT_TXRDY = 2;
  localparam int BIT_OVR   = 6;
  localparam int BIT_UNR   = 7;
  localparam int BIT_NACK  = 8;
  localparam int BIT_LOCK  = 23;

  // control strobe positions
  localparam int CTL_START     = 0;
  localparam int CTL_THR_FLUSH = 24;
  localparam int CTL_RHR_FLUSH = 25;
  localparam int CTL_UNLOCK    = 26;

  // index of each read-clear flag inside the flag vector
  localparam int RC_OVR  = 0;
  localparam int RC_UNR  = 1;
  localparam int RC_NACK = 2;
  localparam int RC_N    = 3;

  typedef struct packed {
    logic comp;
    logic rxrdy;
    logic txrdy;
    logic ovr;
    logic unr;
    logic nack;
    logic lock;
  } stat_t;

  function automatic logic [REG_W-1:0] pack_status(stat_t s);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_COMP]  = s.comp;
    v[BIT_RXRDY] = s.rxrdy;
    v[BIT_TXRDY] = s.txrdy;
    v[BIT_OVR]   = s.ovr;
    v[BIT_UNR]   = s.unr;
    v[BIT_NACK]  = s.nack;
    v[BIT_LOCK]  = s.lock;
    return v;
  endfunction

  // bits that may raise an interrupt
  function automatic logic [REG_W-1:0] irq_capable();
    stat_t all;
    all = '1;
    return pack_status(all);
  endfunction
endpackage

// File: rtl/i2cst_thr.sv
module i2cst_thr #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flush,
  input  logic              lock,
  input  logic              take_req,
  input  logic              dma_en,
  output logic              full,
  output logic              avail,
  output logic [DATA_W-1:0] byte_out,
  output logic              dma_req,
  output logic              take_ev,
  output logic              underrun_ev
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign full        = full_q;
  assign byte_out    = data_q;
  assign avail       = full_q & ~lock;
  assign take_ev     = take_req & avail;
  assign underrun_ev = take_req & ~full_q & ~lock;
  assign dma_req     = dma_en & ~full_q & ~lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (flush) begin
      full_q <= 1'b0;
    end else if (wr) begin
      full_q <= 1'b1;
      data_q <= wdata;
    end else if (take_ev) begin
      full_q <= 1'b0;
    end
  end

  // R4: a locked transmitter keeps its queued byte
  p_lock_holds_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !flush && !wr) |=> $stable(full_q));

  // R11: a taken byte empties the holding register
  p_take_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && !lock && full_q && !wr && !flush) |=> !full_q);
endmodule

// File: rtl/i2cst_flags.sv
module i2cst_flags
  import i2cst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              thr_wr,
  input  logic              thr_full,
  input  logic              unlock,
  input  logic              nack,
  input  logic              stop_done,
  input  logic              busy,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rhr_rd,
  input  logic              rhr_flush,
  input  logic              sr_rd,
  input  logic              underrun_ev,
  output logic              lock,
  output stat_t             stat,
  output logic [DATA_W-1:0] rhr_data
);
  logic              comp_q;
  logic              lock_q;
  logic              rx_full_q;
  logic [DATA_W-1:0] rx_data_q;
  logic [RC_N-1:0]   rc_set;
  logic [RC_N-1:0]   rc_q;
  logic              overrun_ev;
  logic              comp_set_ev;

  assign overrun_ev       = rx_valid & rx_full_q;
  assign comp_set_ev      = stop_done & ~busy & ~thr_full;
  assign rc_set[RC_OVR]   = overrun_ev;
  assign rc_set[RC_UNR]   = underrun_ev;
  assign rc_set[RC_NACK]  = nack;

  for (genvar g = 0; g < RC_N; g++) begin : g_rc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rc_q[g] <= 1'b0;
      else if (rc_set[g]) rc_q[g] <= 1'b1;
      else if (sr_rd)     rc_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                comp_q <= 1'b1;
    else if (nack)             comp_q <= 1'b1;
    else if (start || thr_wr)  comp_q <= 1'b0;
    else if (comp_set_ev)      comp_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= 1'b0;
    else if (nack)   lock_q <= 1'b1;
    else if (unlock) lock_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full_q <= 1'b0;
      rx_data_q <= '0;
    end else if (rx_valid) begin
      rx_full_q <= 1'b1;
      rx_data_q <= rx_byte;
    end else if (rhr_rd || rhr_flush) begin
      rx_full_q <= 1'b0;
    end
  end

  assign lock       = lock_q;
  assign rhr_data   = rx_data_q;
  assign stat.comp  = comp_q & ~thr_full;
  assign stat.rxrdy = rx_full_q;
  assign stat.txrdy = ~thr_full;
  assign stat.ovr   = rc_q[RC_OVR];
  assign stat.unr   = rc_q[RC_UNR];
  assign stat.nack  = rc_q[RC_NACK];
  assign stat.lock  = lock_q;

  // R3: NACK raises lock, NACK flag and complete state together
  p_nack_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nack |=> (lock_q && rc_q[RC_NACK] && comp_q));

  // R5: a simultaneous NACK beats the unlock strobe
  p_unlock_vs_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && nack) |=> lock_q);

  p_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && !nack) |=> !lock_q);

  // R8: a read clears a flag that is not set again in the same cycle
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd && !nack) |=> !rc_q[RC_NACK]);

  // R2: START clears the complete state unless a NACK lands with it
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !nack) |=> !comp_q);

  // R7: a byte landing on a full receive register flags overrun
  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full_q) |=> rc_q[RC_OVR]);
endmodule

// File: rtl/i2cst_mask.sv
module i2cst_mask
  import i2cst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic             idr_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] status,
  output logic [REG_W-1:0] imr,
  output logic             irq
);
  localparam logic [REG_W-1:0] CAP = irq_capable();

  logic [REG_W-1:0] imr_q;
  logic [REG_W-1:0] set_bits;
  logic [REG_W-1:0] clr_bits;

  assign set_bits = ier_wr ? (wdata & CAP) : '0;
  assign clr_bits = idr_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                imr_q <= '0;
    else if (ier_wr || idr_wr) imr_q <= (imr_q | set_bits) & ~clr_bits;
  end

  assign imr = imr_q;
  assign irq = |(status & imr_q);

  // R9: set strobe raises every selected capable bit
  p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && !idr_wr) |=> ((imr_q & $past(wdata & CAP)) == $past(wdata & CAP)));

  // R9: clear strobe drops every selected bit
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idr_wr |=> ((imr_q & $past(wdata)) == '0));

  // R10: an empty mask keeps the line quiet
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_q == '0) |-> !irq);
endmodule

// File: rtl/i2c_txstat_lock.sv
module i2c_txstat_lock
  import i2cst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [31:0]       ctl_wdata,
  input  logic              thr_wr,
  input  logic [DATA_W-1:0] thr_wdata,
  input  logic              sr_rd,
  output logic [31:0]       sr_rdata,
  input  logic              rhr_rd,
  output logic [DATA_W-1:0] rhr_rdata,
  input  logic              ier_wr,
  input  logic              idr_wr,
  input  logic [31:0]       mask_wdata,
  output logic [31:0]       imr_rdata,
  input  logic              eng_tx_req,
  output logic              tx_avail,
  output logic [DATA_W-1:0] tx_byte,
  input  logic              eng_busy,
  input  logic              eng_stop_done,
  input  logic              eng_nack,
  input  logic              eng_rx_valid,
  input  logic [DATA_W-1:0] eng_rx_byte,
  input  logic              dma_tx_en,
  output logic              dma_tx_req,
  output logic              irq
);
  logic  start_stb;
  logic  thr_flush_stb;
  logic  rhr_flush_stb;
  logic  unlock_stb;
  logic  lock;
  logic  thr_full;
  logic  take_ev;
  logic  underrun_ev;
  stat_t stat;
  logic  unused_ctl_bits;
  logic  unused_take;

  assign start_stb     = ctl_wr & ctl_wdata[CTL_START];
  assign thr_flush_stb = ctl_wr & ctl_wdata[CTL_THR_FLUSH];
  assign rhr_flush_stb = ctl_wr & ctl_wdata[CTL_RHR_FLUSH];
  assign unlock_stb    = ctl_wr & ctl_wdata[CTL_UNLOCK];
  assign unused_ctl_bits = ^ctl_wdata;
  assign unused_take     = take_ev;

  i2cst_thr #(.DATA_W(DATA_W)) u_thr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (thr_wr),
    .wdata       (thr_wdata),
    .flush       (thr_flush_stb),
    .lock        (lock),
    .take_req    (eng_tx_req),
    .dma_en      (dma_tx_en),
    .full        (thr_full),
    .avail       (tx_avail),
    .byte_out    (tx_byte),
    .dma_req     (dma_tx_req),
    .take_ev     (take_ev),
    .underrun_ev (underrun_ev)
  );

  i2cst_flags #(.DATA_W(DATA_W)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_stb),
    .thr_wr      (thr_wr),
    .thr_full    (thr_full),
    .unlock      (unlock_stb),
    .nack        (eng_nack),
    .stop_done   (eng_stop_done),
    .busy        (eng_busy),
    .rx_valid    (eng_rx_valid),
    .rx_byte     (eng_rx_byte),
    .rhr_rd      (rhr_rd),
    .rhr_flush   (rhr_flush_stb),
    .sr_rd       (sr_rd),
    .underrun_ev (underrun_ev),
    .lock        (lock),
    .stat        (stat),
    .rhr_data    (rhr_rdata)
  );

  assign sr_rdata = pack_status(stat);

  i2cst_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .ier_wr (ier_wr),
    .idr_wr (idr_wr),
    .wdata  (mask_wdata),
    .status (sr_rdata),
    .imr    (imr_rdata),
    .irq    (irq)
  );
endmodule

// File: tb/i2c_txstat_lock_test.sv
module i2c_txstat_lock_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr, thr_wr, sr_rd, rhr_rd, ier_wr, idr_wr;
  logic [31:0] ctl_wdata, mask_wdata;
  logic [7:0]  thr_wdata, eng_rx_byte;
  logic        eng_tx_req, eng_busy, eng_stop_done, eng_nack, eng_rx_valid, dma_tx_en;
  logic [31:0] sr_rdata, imr_rdata;
  logic [7:0]  rhr_rdata, tx_byte;
  logic        tx_avail, dma_tx_req, irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  i2c_txstat_lock uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata), .sr_rd(sr_rd), .sr_rdata(sr_rdata),
    .rhr_rd(rhr_rd), .rhr_rdata(rhr_rdata), .ier_wr(ier_wr), .idr_wr(idr_wr),
    .mask_wdata(mask_wdata), .imr_rdata(imr_rdata), .eng_tx_req(eng_tx_req),
    .tx_avail(tx_avail), .tx_byte(tx_byte), .eng_busy(eng_busy),
    .eng_stop_done(eng_stop_done), .eng_nack(eng_nack), .eng_rx_valid(eng_rx_valid),
    .eng_rx_byte(eng_rx_byte), .dma_tx_en(dma_tx_en), .dma_tx_req(dma_tx_req),
    .irq(irq)
  );

  // mask vectors: {op (bit0 set, bit1 clear), data, expected mask}
  localparam logic [65:0] VEC [0:7] = '{
    {2'b01, 32'hFFFF_FFFF, 32'h0080_01C7},
    {2'b10, 32'h0000_0007, 32'h0080_01C0},
    {2'b10, 32'h0080_0000, 32'h0000_01C0},
    {2'b01, 32'h0000_0102, 32'h0000_01C2},
    {2'b11, 32'h0000_0040, 32'h0000_0182},
    {2'b10, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'b01, 32'h0000_0009, 32'h0000_0001},
    {2'b01, 32'h0080_0100, 32'h0080_0101}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    ctl_wr = 0; ctl_wdata = '0; thr_wr = 0; sr_rd = 0; rhr_rd = 0;
    ier_wr = 0; idr_wr = 0; eng_tx_req = 0; eng_stop_done = 0;
    eng_nack = 0; eng_rx_valid = 0;
  endtask

  // strobes driven at a falling edge are taken by the next rising edge
  task automatic step();
    @(negedge clk);
    clear_strobes();
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; clear_strobes();
    thr_wdata = '0; eng_rx_byte = '0; mask_wdata = '0;
    eng_busy = 0; dma_tx_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", sr_rdata, 32'h5);
    chk("R1 mask", imr_rdata, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      mask_wdata = VEC[i][63:32];
      ier_wr = VEC[i][64];
      idr_wr = VEC[i][65];
      step();
      chk("R9 mask vector", imr_rdata, VEC[i][31:0]);
    end
    chk("R10 irq complete masked", {31'd0, irq}, 32'h1);
    mask_wdata = 32'h1; idr_wr = 1; step();
    chk("R10 irq after unmask", {31'd0, irq}, 32'h0);

    // R2 START and STOP
    ctl_wr = 1; ctl_wdata = 32'h1; step();
    chk("R2 start clears", sr_rdata, 32'h4);
    eng_stop_done = 1; step();
    chk("R2 stop sets", sr_rdata, 32'h5);

    // R11 normal byte hand-off
    thr_wr = 1; thr_wdata = 8'hA5; step();
    chk("R2 thr write clears", sr_rdata, 32'h0);
    chk("R11 avail", {31'd0, tx_avail}, 32'h1);
    chk("R11 byte", {24'd0, tx_byte}, 32'hA5);
    chk("R11 dma off when full", {31'd0, dma_tx_req}, 32'h0);
    eng_tx_req = 1; step();
    chk("R11 taken", sr_rdata, 32'h4);
    chk("R11 dma on", {31'd0, dma_tx_req}, 32'h1);
    eng_stop_done = 1; step();
    chk("R2 stop after byte", sr_rdata, 32'h5);

    // R3 / R4 NACK lock with a queued byte
    thr_wr = 1; thr_wdata = 8'h3C; step();
    eng_nack = 1; step();
    chk("R3 nack lock", sr_rdata, 32'h0080_0100);
    chk("R10 irq on nack", {31'd0, irq}, 32'h1);
    chk("R4 avail off", {31'd0, tx_avail}, 32'h0);
    chk("R4 dma off", {31'd0, dma_tx_req}, 32'h0);
    eng_tx_req = 1; step();
    chk("R4 locked no take", sr_rdata, 32'h0080_0100);
    sr_rd = 1; step();
    chk("R8 read clears nack", sr_rdata, 32'h0080_0000);
    ctl_wr = 1; ctl_wdata = 32'h0400_0000; eng_nack = 1; step();
    chk("R5 unlock loses to nack", sr_rdata, 32'h0080_0100);
    ctl_wr = 1; ctl_wdata = 32'h0100_0000; step();
    chk("R5 flush", sr_rdata, 32'h0080_0105);
    chk("R4 dma still off", {31'd0, dma_tx_req}, 32'h0);
    ctl_wr = 1; ctl_wdata = 32'h0400_0000; step();
    chk("R5 unlock", sr_rdata, 32'h0000_0105);
    chk("R11 dma back", {31'd0, dma_tx_req}, 32'h1);
    sr_rd = 1; step();
    chk("R8 read", sr_rdata, 32'h5);
    chk("R10 irq low", {31'd0, irq}, 32'h0);

    // R7 / R8 underrun
    eng_tx_req = 1; step();
    chk("R7 underrun", sr_rdata, 32'h85);
    sr_rd = 1; eng_tx_req = 1; step();
    chk("R8 set wins over read", sr_rdata, 32'h85);
    sr_rd = 1; step();
    chk("R8 read clears underrun", sr_rdata, 32'h5);

    // R6 / R7 receive side
    eng_rx_valid = 1; eng_rx_byte = 8'h5A; step();
    chk("R6 rx ready", sr_rdata, 32'h7);
    chk("R6 rx byte", {24'd0, rhr_rdata}, 32'h5A);
    eng_rx_valid = 1; eng_rx_byte = 8'h66; step();
    chk("R7 overrun", sr_rdata, 32'h47);
    chk("R6 rx byte 2", {24'd0, rhr_rdata}, 32'h66);
    rhr_rd = 1; step();
    chk("R6 read clears", sr_rdata, 32'h45);
    eng_rx_valid = 1; eng_rx_byte = 8'h11; step();
    ctl_wr = 1; ctl_wdata = 32'h0200_0000; step();
    chk("R6 rx flush", sr_rdata, 32'h45);
    sr_rd = 1; step();
    chk("R8 read clears overrun", sr_rdata, 32'h5);

    // R2 STOP while busy does not set complete
    ctl_wr = 1; ctl_wdata = 32'h1; step();
    eng_busy = 1; eng_stop_done = 1; step();
    chk("R2 busy blocks", sr_rdata, 32'h4);
    eng_busy = 0; eng_stop_done = 1; step();
    chk("R2 idle stop", sr_rdata, 32'h5);

    dma_tx_en = 0; @(negedge clk);
    chk("R11 dma disabled", {31'd0, dma_tx_req}, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule